// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 and Clause 45)

This block drives the two-wire management bus that connects a MAC to its external PHYs. Software writes a command word and a 16-bit data word. Setting the start bit of the command word sends one complete serial frame on the management clock and data lines. Each frame is a 32-bit preamble of ones, then start bits, opcode, PHY address, register or device address, turnaround and 16 data bits. The block clears the busy bit after the final falling clock edge of the frame. A read frame stores the 16 bits returned by the PHY in the data word.

One select bit in the command word picks between the two frame styles. With the bit clear, the block sends classic frames, which carry a 5-bit register number. With the bit set, the block sends extended frames, which carry a 5-bit device address and a 2-bit command: address, write, read, or read with post-increment. An extended register access takes two frames. Software first sends an address frame that holds the register address in the data word. Once busy has cleared, it sends a write frame with the data word reloaded, or a read frame. A 3-bit rate field sets the bit rate of the management clock. The clock is divided down from the system clock.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command readback and the data readback are zero, the management clock is low and the data line is released (`mdio_oe` = 0).
- R2: Writing the command word while idle with bit 0 set raises busy (readback bit 0) and starts one frame. Busy stays 1 through the final rising clock edge and clears on the 64th falling edge. While busy is 0, the clock stays low and the data line is released.
- R3: While busy is 1, writes to the command word have no effect on the readback or on the frame in flight.
- R4: Every frame has 64 clock periods, sent MSB first: 32 ones, 2 start bits, 2 opcode bits, PHY address (command bits 15:11), address field (command bits 10:6), 2 turnaround bits and 16 data bits.
- R5: With bit 3 = 1 the start bits are 00. The command field (bits 2:1) maps to wire opcodes as follows: 00 (address) → 00, 01 (write) → 01, 10 (read) → 11, 11 (read with post-increment) → 10.
- R6: With bit 3 = 0 the start bits are 01. Command bit 1 = 1 sends a write (opcode 01) and command bit 1 = 0 sends a read (opcode 10).
- R7: Address and write frames drive turnaround as 10, followed by the 16 bits of the data word.
- R8: Read frames release the line for the turnaround and data bits. They sample `mdio_i` on the 16 data rising edges, MSB first, and the result is in the data readback when busy clears.
- R9: Command bits 18:16 select the clock rate, with the half period set to HALF_25M system cycles at code 3. Code 3 gives 25 MHz (half period ×1), code 2 gives 12.5 MHz (×2), code 1 gives 5 MHz (×5), code 0 gives 2.5 MHz (×10) and code 4 gives 1.25 MHz (×20).
- R10: Rate codes 5, 6 and 7 run at the slowest rate (half period ×20).
- R11: The data line and its enable change only on falling clock edges or at frame start, and they stay stable across each rising edge.
- R12: The command readback returns busy in bit 0, the command in bits 2:1, the select bit in bit 3, the address field in bits 10:6, the PHY address in bits 15:11 and the rate code in bits 18:16. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_we | input | 1 | Write strobe for the command word |
| acc_wdata | input | 32 | Command word write value |
| acc_rdata | output | 32 | Command word readback including busy |
| data_we | input | 1 | Write strobe for the data word |
| data_wdata | input | 16 | Data word write value |
| data_rdata | output | 16 | Data word readback, holds read results |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data line input |
| mdio_o | output | 1 | Management data line output value |
| mdio_oe | output | 1 | Management data line output enable |

## Verification
The bench models a PHY that decodes every frame bit on the rising clock edges. It targets the opcode remap of the extended read commands, where a design that copied the command field straight to the wire would send 10 for a plain read. It also targets the turnaround release on reads, where a design would contend with the PHY or lose the first data bit, and the unlisted rate codes, where a design would run too fast or stall. It measures each clock period and rewrites the command word in the middle of a frame. Busy must stay high until the final clock edge and the frame must not change.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  typedef struct packed {
    logic [2:0] rate;
    logic [4:0] phy;
    logic [4:0] regad;
    logic       ext;
    logic [1:0] cmd;
  } acc_fields_t;

  function automatic logic is_read(input logic ext, input logic [1:0] cmd);
    return ext ? cmd[1] : ~cmd[0];
  endfunction

  function automatic logic [1:0] wire_op(input logic ext, input logic [1:0] cmd);
    logic [1:0] op;
    if (ext) begin
      case (cmd)
        2'b00:   op = 2'b00;
        2'b01:   op = 2'b01;
        2'b10:   op = 2'b11;
        default: op = 2'b10;
      endcase
    end else begin
      op = cmd[0] ? 2'b01 : 2'b10;
    end
    return op;
  endfunction

  function automatic int unsigned rate_mult(input logic [2:0] code);
    int unsigned m;
    case (code)
      3'd3:    m = 1;
      3'd2:    m = 2;
      3'd1:    m = 5;
      3'd0:    m = 10;
      default: m = 20;
    endcase
    return m;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input acc_fields_t f,
                                                        input logic [15:0] d);
    logic       rd;
    logic [1:0] st;
    logic [1:0] ta;
    rd = is_read(f.ext, f.cmd);
    st = f.ext ? 2'b00 : 2'b01;
    ta = rd ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, st, wire_op(f.ext, f.cmd), f.phy, f.regad, ta,
            rd ? 16'hFFFF : d};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_25M = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] rate,
  output logic       mdc,
  output logic       rise_tick,
  output logic       fall_tick
);
  import mdio_pkg::*;

  localparam int MAX_HALF = HALF_25M * 20;
  localparam int CW       = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] half_lim;
  logic          terminal;

  always_comb half_lim = CW'(HALF_25M * rate_mult(rate));
  assign terminal  = (cnt == half_lim - CW'(1));
  assign rise_tick = run && terminal && !mdc;
  assign fall_tick = run && terminal && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (terminal) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R9
  mdc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !terminal) |=> $stable(mdc));

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_we,
  input  logic [31:0]           acc_wdata,
  input  logic                  data_we,
  input  logic [15:0]           data_wdata,
  input  logic                  frame_done,
  input  logic                  rd_valid,
  input  logic [15:0]           rd_data,
  output mdio_pkg::acc_fields_t fields,
  output logic                  busy,
  output logic                  start,
  output logic [15:0]           data_q,
  output logic [31:0]           acc_rdata
);
  import mdio_pkg::*;

  logic unused_bits;
  assign unused_bits = ^{acc_wdata[31:19], acc_wdata[5:4]};

  always_ff @(posedge clk) begin
    if (rst) begin
      fields <= '0;
      busy   <= 1'b0;
      start  <= 1'b0;
      data_q <= '0;
    end else begin
      start <= acc_we && acc_wdata[0] && !busy;
      if (acc_we && !busy) begin
        fields.rate  <= acc_wdata[18:16];
        fields.phy   <= acc_wdata[15:11];
        fields.regad <= acc_wdata[10:6];
        fields.ext   <= acc_wdata[3];
        fields.cmd   <= acc_wdata[2:1];
        busy         <= acc_wdata[0];
      end else if (frame_done) begin
        busy <= 1'b0;
      end
      if (frame_done && rd_valid) data_q <= rd_data;
      else if (data_we)           data_q <= data_wdata;
    end
  end

  assign acc_rdata = {13'd0, fields.rate, fields.phy, fields.regad, 2'b00,
                      fields.ext, fields.cmd, busy};

  // R3
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && acc_we) |=> $stable(fields));

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  mdio_pkg::acc_fields_t fields,
  input  logic [15:0]           wdata,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  done,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  rd_valid,
  output logic [15:0]           rd_data
);
  import mdio_pkg::*;

  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sreg;
  logic [IW-1:0]         bit_idx;
  logic [IW-1:0]         next_idx;
  logic                  next_oe;

  assign next_idx = bit_idx + IW'(1);
  assign next_oe  = !(rd_valid && (next_idx >= IW'(TA_FIRST)));
  assign done     = active && fall_tick && (bit_idx == IW'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg     <= '0;
      bit_idx  <= '0;
      active   <= 1'b0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (start) begin
      sreg     <= build_frame(fields, wdata);
      bit_idx  <= '0;
      active   <= 1'b1;
      rd_valid <= is_read(fields.ext, fields.cmd);
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b1;
    end else if (active) begin
      if (rise_tick && rd_valid && (bit_idx >= IW'(DATA_FIRST)))
        rd_data <= {rd_data[14:0], mdio_i};
      if (fall_tick) begin
        if (bit_idx == IW'(FRAME_BITS - 1)) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          bit_idx <= next_idx;
          sreg    <= {sreg[FRAME_BITS-2:0], 1'b0};
          mdio_oe <= next_oe;
          mdio_o  <= next_oe ? sreg[FRAME_BITS-2] : 1'b1;
        end
      end
    end
  end

  // R11
  mdio_hold_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise_tick |=> ($stable(mdio_o) && $stable(mdio_oe)));

  // R2
  oe_idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> !mdio_oe);

  // R8
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (active && rd_valid && (bit_idx >= IW'(TA_FIRST))) |-> !mdio_oe);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int HALF_25M = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_we,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  input  logic        data_we,
  input  logic [15:0] data_wdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  import mdio_pkg::*;

  acc_fields_t fields;
  logic        busy, start, active, done, rd_valid, rise_tick, fall_tick;
  logic [15:0] data_q, rd_data;

  mdio_regs regs_i (
    .clk        (clk),
    .rst        (rst),
    .acc_we     (acc_we),
    .acc_wdata  (acc_wdata),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .frame_done (done),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .fields     (fields),
    .busy       (busy),
    .start      (start),
    .data_q     (data_q),
    .acc_rdata  (acc_rdata)
  );

  mdio_clkgen #(.HALF_25M(HALF_25M)) clkgen_i (
    .clk       (clk),
    .rst       (rst),
    .run       (active),
    .rate      (fields.rate),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_shifter shifter_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .fields    (fields),
    .wdata     (data_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .active    (active),
    .done      (done),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assign data_rdata = data_q;

  // R2
  mdc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_we = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        data_we = 1'b0;
  logic [15:0] data_wdata = '0;
  logic [15:0] data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mdio_mgmt_master #(.HALF_25M(4)) dut_i (
    .clk(clk), .rst(rst), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .data_we(data_we), .data_wdata(data_wdata),
    .data_rdata(data_rdata), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe)
  );

  typedef struct {
    logic [63:0] bits;
    logic [63:0] mask;
    int          half;
    logic        rd;
    logic [15:0] resp;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   frames_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int half_of(input logic [2:0] r);
    case (r)
      3'd3: return 4;
      3'd2: return 8;
      3'd1: return 20;
      3'd0: return 40;
      default: return 80;
    endcase
  endfunction

  // driver: builds the expected frame from the requirements and starts it
  task automatic run_frame(input logic [2:0] rate, input logic ext,
                           input logic [1:0] cmd, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] d,
                           input logic [15:0] resp, input bit poke,
                           input string tag);
    exp_t e;
    logic [1:0] st, op;
    logic [31:0] word;
    logic [31:0] rb;
    if (ext) begin
      st = 2'b00;
      case (cmd) 2'b00: op = 2'b00; 2'b01: op = 2'b01;
                 2'b10: op = 2'b11; default: op = 2'b10; endcase
      e.rd = cmd[1];
    end else begin
      st = 2'b01;
      op = cmd[0] ? 2'b01 : 2'b10;
      e.rd = ~cmd[0];
    end
    e.bits = {32'hFFFF_FFFF, st, op, phy, ra, 2'b10, d};
    e.mask = e.rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    e.half = half_of(rate);
    e.resp = resp;
    e.tag  = tag;
    q.push_back(e);
    word = {13'd0, rate, phy, ra, 2'b00, ext, cmd, 1'b1};
    @(negedge clk); data_we = 1'b1; data_wdata = d;
    @(negedge clk); data_we = 1'b0; acc_we = 1'b1; acc_wdata = word;
    @(negedge clk); acc_we = 1'b0;
    // R2 busy raised at start
    chk(acc_rdata[0] == 1'b1, "R2 busy after start", {63'd0, acc_rdata[0]}, 64'd1);
    if (poke) begin
      repeat (100) @(negedge clk);
      rb = acc_rdata;
      acc_we = 1'b1; acc_wdata = 32'h0004_F7FB;
      @(negedge clk); acc_we = 1'b0;
      @(negedge clk);
      // R3 readback unchanged by mid-frame write
      chk(acc_rdata == rb, "R3 write while busy", {32'd0, acc_rdata}, {32'd0, rb});
    end
    while (acc_rdata[0]) @(negedge clk);
    // R2 idle state after the frame
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R2 idle after done",
        {62'd0, mdc, mdio_oe}, 64'd0);
    if (e.rd)
      // R8 returned data
      chk(data_rdata == resp, {"R8 read data ", tag}, {48'd0, data_rdata}, {48'd0, resp});
    repeat (3) @(negedge clk);
  endtask

  // monitor: PHY model and scoreboard compare
  initial begin
    exp_t e;
    logic [63:0] got, oe;
    realtime t0, t1;
    bit hold_ok, busy_ok;
    forever begin
      while (q.size() == 0) @(posedge clk);
      e = q.pop_front();
      got = '0; oe = '0; hold_ok = 1; busy_ok = 1;
      t0 = 0; t1 = 0;
      for (int i = 0; i < 64; i++) begin
        @(posedge mdc);
        if (i == 0) t0 = $realtime;
        if (i == 1) t1 = $realtime;
        got[63-i] = mdio_o;
        oe[63-i]  = mdio_oe;
        if (i == 63) busy_ok = acc_rdata[0];
        #2;
        if (mdio_o !== got[63-i] || mdio_oe !== oe[63-i]) hold_ok = 0;
        @(negedge mdc);
        if (e.rd && (i + 1) >= 48 && (i + 1) < 64) mdio_i = e.resp[63-(i+1)];
        else mdio_i = 1'b1;
      end
      mdio_i = 1'b1;
      // R4 R5 R6 R7 frame content
      chk((got & e.mask) == (e.bits & e.mask), {"R4 frame ", e.tag},
          got & e.mask, e.bits & e.mask);
      // R8 R7 drive enable pattern
      chk(oe == e.mask, {"R8 oe pattern ", e.tag}, oe, e.mask);
      // R9 R10 clock period
      chk(int'((t1 - t0) / 5.0) == 2 * e.half, {"R9 period ", e.tag},
          64'(int'((t1 - t0) / 5.0)), 64'(2 * e.half));
      // R11 stable across rising edge
      chk(hold_ok, {"R11 hold ", e.tag}, {63'd0, hold_ok}, 64'd1);
      // R2 busy still set on last rising edge
      chk(busy_ok, {"R2 busy at last edge ", e.tag}, {63'd0, busy_ok}, 64'd1);
      frames_done++;
    end
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired got=%0d exp=done", frames_done);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(acc_rdata == 32'd0 && data_rdata == 16'd0, "R1 regs after reset",
        {acc_rdata, 16'd0, data_rdata}, 64'd0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 line after reset",
        {62'd0, mdc, mdio_oe}, 64'd0);

    // R5 R7 extended address frame at 25 MHz
    run_frame(3'd3, 1'b1, 2'b00, 5'h05, 5'h01, 16'h1234, 16'h0, 0, "ext-addr");
    // R5 R7 extended write at 12.5 MHz
    run_frame(3'd2, 1'b1, 2'b01, 5'h1A, 5'h03, 16'hA5C3, 16'h0, 0, "ext-write");
    // R5 R8 extended read at 5 MHz
    run_frame(3'd1, 1'b1, 2'b10, 5'h11, 5'h1F, 16'h0000, 16'hBEEF, 0, "ext-read");
    // R5 R8 read with post-increment at 2.5 MHz
    run_frame(3'd0, 1'b1, 2'b11, 5'h00, 5'h07, 16'h0000, 16'h0F0F, 0, "ext-readinc");
    // R6 R7 classic write
    run_frame(3'd3, 1'b0, 2'b01, 5'h1F, 5'h10, 16'h8001, 16'h0, 0, "c22-write");
    // R6 R8 classic read
    run_frame(3'd3, 1'b0, 2'b00, 5'h02, 5'h09, 16'h0000, 16'h8001, 0, "c22-read");
    // R9 slowest code
    run_frame(3'd4, 1'b1, 2'b00, 5'h03, 5'h02, 16'h5555, 16'h0, 0, "rate4");
    // R10 undefined codes fall back
    run_frame(3'd5, 1'b1, 2'b00, 5'h03, 5'h02, 16'hAAAA, 16'h0, 0, "rate5");
    run_frame(3'd7, 1'b1, 2'b01, 5'h03, 5'h02, 16'hC0DE, 16'h0, 0, "rate7");
    // R3 rewrite command in the middle of a frame
    run_frame(3'd3, 1'b1, 2'b01, 5'h0C, 5'h15, 16'h7E81, 16'h0, 1, "poke");

    // R12 readback layout, no start
    @(negedge clk); acc_we = 1'b1; acc_wdata = 32'hFFFF_FFFE;
    @(negedge clk); acc_we = 1'b0;
    @(negedge clk);
    chk(acc_rdata == 32'h0007_FFCE, "R12 readback layout",
        {32'd0, acc_rdata}, 64'h0007_FFCE);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R2 no frame without start",
        {62'd0, mdc, mdio_oe}, 64'd0);

    repeat (10) @(negedge clk);
    chk(frames_done == 10, "R4 frame count", 64'(frames_done), 64'd10);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule